// File: doc/BRIEF.md
# Qualified Bus Address Breakpoint

This block watches a 16-bit processor address bus along with its read/write line, its memory-or-I/O line and six special status lines. When a bus cycle marked valid carries the programmed address, and every status line the host chose to qualify carries its programmed level, the block raises a sticky breakpoint interrupt. The interrupt stays up until the host clears it or reset occurs.

The host programs five byte-wide registers over an 8-bit internal data bus. A 4-bit register address comes with a bus-enable strobe and an active-low internal-I/O strobe. The stored address is compared byte by byte. The high byte's result gates the low byte's compare, so a hit needs both bytes equal. A per-line don't-care mask can drop any status qualifier, down to a pure address breakpoint.

Top module: `bus_brkpt_unit`

## Requirements
- R1: A register write takes effect only in a cycle where `cfg_en` is 1, `cfg_io_n` is 0 and `cfg_addr[3]` is 1. Any other cycle leaves every register unchanged.
- R2: Register offsets are 0xA for the address low byte, 0xB for the address high byte, 0xC for the expected levels, 0xD for the don't-care mask and 0xE for control. Offsets are decoded from `cfg_addr[2:0]`.
- R3: An address hit requires the high byte of `bus_addr` to equal the stored high byte and the low byte to equal the stored low byte. A mismatch in either byte blocks the hit.
- R4: The expected-level and mask registers share one layout: bit 0 is R/W, bit 1 is M/IO, and bits 2..7 are SP0..SP5. A qualifier is met when its live line equals its stored bit. R/W = 0 means read and M/IO = 1 means I/O.
- R5: A mask bit of 1 removes its qualifier from the condition. With the mask at 0xFF, an address hit alone is enough.
- R6: Control bit 0 enables the breakpoint. While it is 0, no interrupt is raised.
- R7: A qualified hit on a clock edge sets `brk_irq` from the next cycle onward. It stays 1 until a control write with bit 1 set, which clears it on that edge.
- R8: Reset clears every register. Afterwards the address is 0x0000, the expected levels and mask are 0, and the breakpoint is disabled.
- R9: The comparison is taken only in cycles where `bus_valid` is 1.
- R10: A qualified hit and a clear write on the same edge leave `brk_irq` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Internal bus enable |
| cfg_io_n | input | 1 | Internal I/O strobe, active low |
| cfg_addr | input | 4 | Register address |
| cfg_data | input | 8 | Register write data |
| bus_valid | input | 1 | Watched bus cycle is valid |
| bus_addr | input | 16 | Watched address |
| bus_rw | input | 1 | Watched read/write line (0 = read) |
| bus_mio | input | 1 | Watched memory/I-O line (1 = I/O) |
| bus_sp | input | 6 | Watched special status lines |
| brk_irq | output | 1 | Sticky breakpoint interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit address made of two 8-bit byte comparators and six special lines, so the qualifier vector fills one register byte exactly. These values allow a separate stimulus for each side of the cascade: a match that fails only in the high byte and a match that fails only in the low byte. They also cover every qualifier class, set to care and to don't-care. Because the control register is 8 bits wide, the bench can set and clear the enable and clear bits in one write alongside a live hit.

// File: rtl/brk_pkg.sv
package brk_pkg;
  // low three bits of the register address select the target register
  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd2,
    SEL_ADDR_HI = 3'd3,
    SEL_EXPECT  = 3'd4,
    SEL_MASK    = 3'd5,
    SEL_CTRL    = 3'd6
  } reg_sel_e;

  localparam int CTRL_ENABLE_BIT = 0;
  localparam int CTRL_CLEAR_BIT  = 1;
endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
  import brk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr_ref,
  output logic [DATA_W-1:0] expect_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              enable_q,
  output logic              clr_pulse
);
  logic [DATA_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [DATA_W-1:0] exp_d, msk_d;
  logic              en_d;

  always_comb begin
    lo_d      = lo_q;
    hi_d      = hi_q;
    exp_d     = expect_q;
    msk_d     = mask_q;
    en_d      = enable_q;
    clr_pulse = 1'b0;
    if (wr_en) begin
      case (wr_sel)
        SEL_ADDR_LO: lo_d  = wr_data;
        SEL_ADDR_HI: hi_d  = wr_data;
        SEL_EXPECT:  exp_d = wr_data;
        SEL_MASK:    msk_d = wr_data;
        SEL_CTRL: begin
          en_d      = wr_data[CTRL_ENABLE_BIT];
          clr_pulse = wr_data[CTRL_CLEAR_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      expect_q <= '0;
      mask_q   <= '0;
      enable_q <= 1'b0;
    end else if (wr_en) begin
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      expect_q <= exp_d;
      mask_q   <= msk_d;
      enable_q <= en_d;
    end
  end

  assign addr_ref = {hi_q, lo_q};

  assert_write_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(addr_ref) && $stable(expect_q) && $stable(mask_q) && $stable(enable_q)));
  assert_no_clear_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> wr_en);
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] addr_ref,
  output logic              addr_hit
);
  localparam int NBYTES = ADDR_W / DATA_W;

  // chain[i] is the enable handed down into byte i-1; top byte starts enabled
  logic [NBYTES:0] chain;
  assign chain[NBYTES] = 1'b1;

  for (genvar i = NBYTES - 1; i >= 0; i--) begin : g_byte
    logic byte_eq;
    assign byte_eq  = (bus_addr[i*DATA_W +: DATA_W] == addr_ref[i*DATA_W +: DATA_W]);
    assign chain[i] = chain[i+1] & byte_eq;
  end

  assign addr_hit = chain[0];

  assert_cascade_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> (bus_addr == addr_ref));
  assert_cascade_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != addr_ref) |-> !addr_hit);
endmodule

// File: rtl/brk_qual.sv
module brk_qual #(
  parameter int QUAL_W = 8
) (
  input  logic [QUAL_W-1:0] live,
  input  logic [QUAL_W-1:0] expect_q,
  input  logic [QUAL_W-1:0] mask_q,
  output logic              qual_ok
);
  logic [QUAL_W-1:0] bit_ok;

  for (genvar i = 0; i < QUAL_W; i++) begin : g_bit
    assign bit_ok[i] = mask_q[i] | ~(live[i] ^ expect_q[i]);
  end

  assign qual_ok = &bit_ok;

  always_comb begin
    assert_full_mask_R5: assert (!(&mask_q) || qual_ok);
  end
endmodule

// File: rtl/bus_brkpt_unit.sv
module bus_brkpt_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SP_W   = 6,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_io_n,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rw,
  input  logic              bus_mio,
  input  logic [SP_W-1:0]   bus_sp,
  output logic              brk_irq
);
  localparam int QUAL_W = SP_W + 2;

  // reset asserts at once, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              wr_en, clr_pulse, enable_q, addr_hit, qual_ok, hit;
  logic [ADDR_W-1:0] addr_ref;
  logic [DATA_W-1:0] expect_q, mask_q;
  logic [QUAL_W-1:0] live_q;
  logic              irq_q, irq_d;

  assign wr_en  = cfg_en & ~cfg_io_n & cfg_addr[RA_W-1];
  assign live_q = {bus_sp, bus_mio, bus_rw};

  brk_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sel(cfg_addr[2:0]),
    .wr_data(cfg_data), .addr_ref(addr_ref), .expect_q(expect_q),
    .mask_q(mask_q), .enable_q(enable_q), .clr_pulse(clr_pulse)
  );

  brk_addr_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr),
    .addr_ref(addr_ref), .addr_hit(addr_hit)
  );

  brk_qual #(.QUAL_W(QUAL_W)) u_qual (
    .live(live_q), .expect_q(expect_q[QUAL_W-1:0]),
    .mask_q(mask_q[QUAL_W-1:0]), .qual_ok(qual_ok)
  );

  assign hit = bus_valid & enable_q & addr_hit & qual_ok;

  // a new hit outranks a clear on the same edge
  always_comb begin
    irq_d = irq_q;
    if (clr_pulse) irq_d = 1'b0;
    if (hit)       irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign brk_irq = irq_q;

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_irq && !clr_pulse) |=> brk_irq);
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(brk_irq) |-> ($past(bus_valid) && $past(enable_q)));
  assert_hit_wins_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && clr_pulse) |=> brk_irq);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_pulse && !hit) |=> !brk_irq);
endmodule

// File: tb/sim_bus_brkpt_unit.sv
module sim_bus_brkpt_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_io_n, bus_valid, bus_rw, bus_mio;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic [15:0] bus_addr;
  logic [5:0]  bus_sp;
  logic        brk_irq;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  bus_brkpt_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_io_n(cfg_io_n),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_mio(bus_mio),
    .bus_sp(bus_sp), .brk_irq(brk_irq)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: brk_irq actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per edge, samples 2 ns after it
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(brk_irq, it.exp, it.tag);
    end
  end

  task automatic drive(input logic en, input logic io_n, input logic [3:0] ra,
                       input logic [7:0] d, input logic v, input logic [15:0] a,
                       input logic rw, input logic mio, input logic [5:0] sp,
                       input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    cfg_en = en; cfg_io_n = io_n; cfg_addr = ra; cfg_data = d;
    bus_valid = v; bus_addr = a; bus_rw = rw; bus_mio = mio; bus_sp = sp;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [3:0] ra, input logic [7:0] d, input logic exp, input string tag);
    drive(1'b1, 1'b0, ra, d, 1'b0, 16'h0, 1'b0, 1'b0, 6'h0, exp, tag);
  endtask

  task automatic cyc(input logic [15:0] a, input logic rw, input logic mio,
                     input logic [5:0] sp, input logic exp, input string tag);
    drive(1'b0, 1'b1, 4'h0, 8'h0, 1'b1, a, rw, mio, sp, exp, tag);
  endtask

  task automatic settle();
    drive(1'b0, 1'b1, 4'h0, 8'h0, 1'b0, 16'h0, 1'b0, 1'b0, 6'h0, 1'bx, "idle");
    void'(sb.pop_back());
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_en = 1'b0; cfg_io_n = 1'b1; cfg_addr = '0; cfg_data = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_rw = 1'b0; bus_mio = 1'b0; bus_sp = '0;
    repeat (3) @(negedge clk);
    check(brk_irq, 1'b0, "R8 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: cleared registers give address 0, all qualifiers 0, mask 0
    wr(4'hE, 8'h01, 1'b0, "R6 enable write");
    cyc(16'h0000, 1'b1, 1'b0, 6'h0, 1'b0, "R8 mask zero keeps R/W qualifier");
    cyc(16'h0000, 1'b0, 1'b0, 6'h0, 1'b1, "R8 cleared registers hit at 0x0000");
    cyc(16'h1234, 1'b0, 1'b0, 6'h0, 1'b1, "R7 sticky after miss");
    wr(4'hE, 8'h03, 1'b0, "R7 clear");

    // read from I/O 0xC400
    wr(4'hA, 8'h00, 1'b0, "R2 low byte");
    wr(4'hB, 8'hC4, 1'b0, "R2 high byte");
    wr(4'hC, 8'h02, 1'b0, "R4 expect read+io");
    wr(4'hD, 8'h00, 1'b0, "R5 mask none");
    cyc(16'hC400, 1'b1, 1'b1, 6'h0, 1'b0, "R4 write rejected");
    cyc(16'hC400, 1'b0, 1'b0, 6'h0, 1'b0, "R4 memory rejected");
    cyc(16'hC401, 1'b0, 1'b1, 6'h0, 1'b0, "R3 low byte mismatch");
    cyc(16'hC500, 1'b0, 1'b1, 6'h0, 1'b0, "R3 high byte mismatch");
    drive(1'b0, 1'b1, 4'h0, 8'h0, 1'b0, 16'hC400, 1'b0, 1'b1, 6'h0, 1'b0, "R9 no valid strobe");
    cyc(16'hC400, 1'b0, 1'b1, 6'h0, 1'b1, "R4 io read hit");
    wr(4'hE, 8'h03, 1'b0, "R7 clear");

    // special lines SP0..SP5 = 0x25 in bits 2..7
    wr(4'hC, 8'h96, 1'b0, "R4 expect sp");
    cyc(16'hC400, 1'b0, 1'b1, 6'h24, 1'b0, "R4 sp mismatch");
    cyc(16'hC400, 1'b0, 1'b1, 6'h25, 1'b1, "R4 sp match");
    wr(4'hE, 8'h03, 1'b0, "R7 clear");

    // mask layout
    wr(4'hD, 8'h02, 1'b0, "R5 mask M/IO");
    cyc(16'hC400, 1'b1, 1'b1, 6'h25, 1'b0, "R5 bit1 leaves R/W qualified");
    wr(4'hD, 8'h01, 1'b0, "R5 mask R/W");
    cyc(16'hC400, 1'b1, 1'b1, 6'h25, 1'b1, "R5 R/W masked");
    wr(4'hE, 8'h03, 1'b0, "R7 clear");
    wr(4'hD, 8'hFF, 1'b0, "R5 mask all");
    cyc(16'hC4FF, 1'b1, 1'b0, 6'h0, 1'b0, "R5 address still required");
    cyc(16'hC400, 1'b1, 1'b0, 6'h0, 1'b1, "R5 address alone hits");
    wr(4'hE, 8'h03, 1'b0, "R7 clear");

    // R1 write gating
    drive(1'b0, 1'b0, 4'hB, 8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 6'h0, 1'b0, "R1 no enable");
    drive(1'b1, 1'b1, 4'hB, 8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 6'h0, 1'b0, "R1 io strobe high");
    drive(1'b1, 1'b0, 4'h3, 8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 6'h0, 1'b0, "R1 addr bit3 low");
    cyc(16'hC400, 1'b0, 1'b0, 6'h0, 1'b1, "R1 high byte kept");
    wr(4'hE, 8'h03, 1'b0, "R7 clear");

    wr(4'hA, 8'h11, 1'b0, "R2 low byte rewrite");
    cyc(16'hC400, 1'b0, 1'b0, 6'h0, 1'b0, "R2 old low byte gone");
    cyc(16'hC411, 1'b0, 1'b0, 6'h0, 1'b1, "R2 new low byte hits");

    wr(4'hE, 8'h02, 1'b0, "R6 clear and disable");
    cyc(16'hC411, 1'b0, 1'b0, 6'h0, 1'b0, "R6 disabled no irq");

    wr(4'hE, 8'h01, 1'b0, "R6 re-enable");
    cyc(16'hC411, 1'b0, 1'b0, 6'h0, 1'b1, "R6 enabled hit");
    drive(1'b1, 1'b0, 4'hE, 8'h03, 1'b1, 16'hC411, 1'b0, 1'b0, 6'h0, 1'b1, "R10 hit beats clear");
    wr(4'hE, 8'h03, 1'b0, "R10 later clear");
    cyc(16'hC411, 1'b0, 1'b0, 6'h0, 1'b1, "R7 set again");

    // R8 reset mid-run
    settle();
    rst_n = 1'b0;
    #1;
    check(brk_irq, 1'b0, "R8 async reset clears irq");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc(16'hC411, 1'b0, 1'b0, 6'h0, 1'b0, "R8 disabled after reset");
    wr(4'hE, 8'h01, 1'b0, "R8 enable");
    cyc(16'hC411, 1'b0, 1'b0, 6'h0, 1'b0, "R8 address cleared");
    cyc(16'h0000, 1'b0, 1'b1, 6'h0, 1'b0, "R8 mask cleared");
    cyc(16'h0000, 1'b0, 1'b0, 6'h0, 1'b1, "R8 zero hit");
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: run actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule